// File: doc/BRIEF.md
# Speculative Region Control Sequencer

This block follows one hardware thread through a speculative region and decides how the region ends. A decoder supplies single-cycle event inputs. These mark region entry, commit, an explicit abort, a protected memory access, lost contention on a protected line, a capacity overflow, an interrupt, an exception, a system call, a disallowed instruction and a TLB miss. When a region starts, the block records a rollback checkpoint. The checkpoint is the address of the instruction that follows the start instruction, together with the current stack pointer. No other architectural register is saved.

A region ends by abort or by commit. On abort, the block spends one cycle presenting the saved instruction and stack pointers for restore, a reason code bound for the accumulator, a request to clear the zero flag, and a command that makes the protected-line store discard its speculative data. On commit, it spends one cycle pulsing a commit indication and a flash-clear command for the protected-line store. After either cycle it is idle again. A TLB miss never ends a region. Every privilege-changing event does end it, so no speculative state survives a context switch.

Top module: `spec_region_seq`

## Requirements
- R1: After reset the block is idle: inRegion, abortValid, zfClear, discardLines, commitDone, flashClear and trackLine are 0 and abortCode is 0.
- R2: A start event while idle makes inRegion 1 from the next cycle. It checkpoints restore IP = startIp + startLen (the length zero-extended) and restore SP = startSp.
- R3: Any abort cause while in a region causes exactly one cycle, beginning at the following clock, with abortValid, zfClear and discardLines at 1 and restoreIp/restoreSp equal to the checkpoint. The block is idle on the cycle after that.
- R4: abortCode is 0 except in the abort cycle. It then carries 1 for an explicit abort, 2 for contention, 3 for capacity overflow, 4 for an interrupt or exception, and 5 for a system call, disallowed instruction or nested start.
- R5: When several abort causes arrive in the same cycle, the lowest nonzero code is reported.
- R6: A commit event while in a region, with no abort cause present, gives one cycle with commitDone and flashClear at 1 and discardLines at 0. The block is idle on the cycle after that.
- R7: An abort cause that arrives in the same cycle as a commit wins: the region aborts and flashClear stays 0.
- R8: A start event while already in a region aborts the region with code 5, and the checkpoint from the first start is kept.
- R9: A TLB miss inside a region has no effect: the region stays open and no abort occurs.
- R10: Commit and abort-cause events while idle, and every event (including start) during the abort or commit cycle, are ignored.
- R11: trackLine equals 1 in the same cycle as a protected-access event only while in a region, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evStart | input | 1 | Region-start instruction decoded |
| evCommit | input | 1 | Commit instruction decoded |
| evAbort | input | 1 | Explicit abort instruction decoded |
| evProtAccess | input | 1 | Protected load, store or prefetch decoded |
| evConflict | input | 1 | Contention lost on a protected line |
| evCapacity | input | 1 | Protected-line store overflowed |
| evInterrupt | input | 1 | Interrupt taken |
| evException | input | 1 | Exception raised |
| evSyscall | input | 1 | System call instruction decoded |
| evDisallowed | input | 1 | Disallowed instruction decoded |
| evTlbMiss | input | 1 | TLB miss reported |
| startIp | input | IP_W | Address of the start instruction |
| startLen | input | LEN_W | Length in bytes of the start instruction |
| startSp | input | IP_W | Stack pointer at region start |
| inRegion | output | 1 | Thread is speculating |
| trackLine | output | 1 | Begin monitoring the accessed line |
| abortValid | output | 1 | Abort cycle: restore values are valid |
| restoreIp | output | IP_W | Rollback instruction pointer |
| restoreSp | output | IP_W | Rollback stack pointer |
| abortCode | output | CODE_W | Abort reason for the accumulator |
| zfClear | output | 1 | Clear the zero flag |
| discardLines | output | 1 | Discard speculative protected data |
| commitDone | output | 1 | Region committed |
| flashClear | output | 1 | Flash-clear protected-line tracking |

## Verification
The bench targets the priority cases first: a design that let a higher code win, or merged interrupts with system calls, would report the wrong abortCode when causes stack up in one cycle. A commit that collides with an abort cause checks that speculative data is never published while an abort is pending. A nested start checks two things: that the design aborts instead of silently re-entering, and that it does not overwrite the checkpoint with the second start's address. A TLB miss inside a region, and events sent during idle or the one-cycle end states, expose a design that aborts too eagerly or that reopens a region too early.

// File: rtl/srs_pkg.sv
package srs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SPEC   = 2'd1,
    ST_ABORT  = 2'd2,
    ST_COMMIT = 2'd3
  } srState_t;

  localparam int REASON_W = 3;

  localparam logic [REASON_W-1:0] RSN_NONE     = 3'd0;
  localparam logic [REASON_W-1:0] RSN_EXPLICIT = 3'd1;
  localparam logic [REASON_W-1:0] RSN_CONTEND  = 3'd2;
  localparam logic [REASON_W-1:0] RSN_CAPACITY = 3'd3;
  localparam logic [REASON_W-1:0] RSN_TRAP     = 3'd4;
  localparam logic [REASON_W-1:0] RSN_ILLEGAL  = 3'd5;

  typedef struct packed {
    logic capture;
    logic latchReason;
    logic showAbort;
  } ctlStrobe_t;
endpackage

// File: rtl/srs_cause_enc.sv
module srs_cause_enc
  import srs_pkg::*;
#(
  parameter bit ABORT_ON_TLB = 1'b0
) (
  input  logic                speculating,
  input  logic                evStart,
  input  logic                evAbort,
  input  logic                evConflict,
  input  logic                evCapacity,
  input  logic                evInterrupt,
  input  logic                evException,
  input  logic                evSyscall,
  input  logic                evDisallowed,
  input  logic                evTlbMiss,
  output logic [REASON_W-1:0] reason
);
  logic trapHit;
  logic illegalHit;

  generate
    if (ABORT_ON_TLB) begin : g_tlbTrap
      assign trapHit = evInterrupt | evException | evTlbMiss;
    end else begin : g_tlbQuiet
      logic tlbIgnored;
      assign tlbIgnored = evTlbMiss & 1'b0;
      assign trapHit = evInterrupt | evException | tlbIgnored;
    end
  endgenerate

  // a nested start counts as an illegal instruction inside a region
  assign illegalHit = evSyscall | evDisallowed | evStart;

  always_comb begin
    reason = RSN_NONE;
    if (speculating) begin
      if (evAbort)         reason = RSN_EXPLICIT;
      else if (evConflict) reason = RSN_CONTEND;
      else if (evCapacity) reason = RSN_CAPACITY;
      else if (trapHit)    reason = RSN_TRAP;
      else if (illegalHit) reason = RSN_ILLEGAL;
    end
  end
endmodule

// File: rtl/srs_control.sv
module srs_control
  import srs_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                evStart,
  input  logic                evCommit,
  input  logic                evProtAccess,
  input  logic [REASON_W-1:0] reason,
  output logic                inRegion,
  output logic                trackLine,
  output logic                abortValid,
  output logic                zfClear,
  output logic                discardLines,
  output logic                commitDone,
  output logic                flashClear,
  output ctlStrobe_t          strobe
);
  srState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (evStart) stateNext = ST_SPEC;
      ST_SPEC: begin
        if (reason != RSN_NONE) stateNext = ST_ABORT;
        else if (evCommit)      stateNext = ST_COMMIT;
      end
      ST_ABORT:  stateNext = ST_IDLE;
      ST_COMMIT: stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign inRegion     = (state == ST_SPEC);
  assign trackLine    = inRegion & evProtAccess;
  assign abortValid   = (state == ST_ABORT);
  assign zfClear      = abortValid;
  assign discardLines = abortValid;
  assign commitDone   = (state == ST_COMMIT);
  assign flashClear   = commitDone;

  assign strobe.capture     = (state == ST_IDLE) & evStart;
  assign strobe.latchReason = inRegion & (reason != RSN_NONE);
  assign strobe.showAbort   = abortValid;

  // R3: an abort lasts a single cycle and is followed by idle
  p_abort_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |=> (!abortValid && !inRegion));

  // R6: the commit strobe is a one-cycle pulse
  p_commit_pulse_r6: assert property (@(posedge clk) disable iff (!rstN)
    flashClear |=> (!flashClear && !inRegion));

  // R10: a start during an end cycle does not reopen the region
  p_end_ignores_start_r10: assert property (@(posedge clk) disable iff (!rstN)
    (abortValid || commitDone) |=> !inRegion);
endmodule

// File: rtl/srs_datapath.sv
module srs_datapath
  import srs_pkg::*;
#(
  parameter int IP_W   = 64,
  parameter int LEN_W  = 4,
  parameter int CODE_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctlStrobe_t          strobe,
  input  logic [IP_W-1:0]     startIp,
  input  logic [LEN_W-1:0]    startLen,
  input  logic [IP_W-1:0]     startSp,
  input  logic [REASON_W-1:0] reason,
  output logic [IP_W-1:0]     restoreIp,
  output logic [IP_W-1:0]     restoreSp,
  output logic [CODE_W-1:0]   abortCode
);
  localparam int LEN_PAD  = IP_W - LEN_W;
  localparam int CODE_PAD = CODE_W - REASON_W;

  logic [IP_W-1:0]     ckptIp;
  logic [IP_W-1:0]     ckptSp;
  logic [REASON_W-1:0] reasonReg;
  logic [IP_W-1:0]     rollbackIp;

  assign rollbackIp = startIp + {{LEN_PAD{1'b0}}, startLen};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ckptIp <= '0;
      ckptSp <= '0;
    end else if (strobe.capture) begin
      ckptIp <= rollbackIp;
      ckptSp <= startSp;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   reasonReg <= RSN_NONE;
    else if (strobe.latchReason) reasonReg <= reason;
  end

  assign restoreIp = ckptIp;
  assign restoreSp = ckptSp;
  assign abortCode = strobe.showAbort ? {{CODE_PAD{1'b0}}, reasonReg} : '0;

  // R8: the checkpoint holds while a region stays open
  p_ckpt_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.latchReason || strobe.showAbort) |=> $stable(ckptIp) && $stable(ckptSp));
endmodule

// File: rtl/spec_region_seq.sv
module spec_region_seq
  import srs_pkg::*;
#(
  parameter int IP_W         = 64,
  parameter int LEN_W        = 4,
  parameter int CODE_W       = 8,
  parameter bit ABORT_ON_TLB = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evStart,
  input  logic              evCommit,
  input  logic              evAbort,
  input  logic              evProtAccess,
  input  logic              evConflict,
  input  logic              evCapacity,
  input  logic              evInterrupt,
  input  logic              evException,
  input  logic              evSyscall,
  input  logic              evDisallowed,
  input  logic              evTlbMiss,
  input  logic [IP_W-1:0]   startIp,
  input  logic [LEN_W-1:0]  startLen,
  input  logic [IP_W-1:0]   startSp,
  output logic              inRegion,
  output logic              trackLine,
  output logic              abortValid,
  output logic [IP_W-1:0]   restoreIp,
  output logic [IP_W-1:0]   restoreSp,
  output logic [CODE_W-1:0] abortCode,
  output logic              zfClear,
  output logic              discardLines,
  output logic              commitDone,
  output logic              flashClear
);
  logic [REASON_W-1:0] reason;
  ctlStrobe_t          strobe;

  srs_cause_enc #(.ABORT_ON_TLB(ABORT_ON_TLB)) u_enc (
    .speculating (inRegion),
    .evStart     (evStart),
    .evAbort     (evAbort),
    .evConflict  (evConflict),
    .evCapacity  (evCapacity),
    .evInterrupt (evInterrupt),
    .evException (evException),
    .evSyscall   (evSyscall),
    .evDisallowed(evDisallowed),
    .evTlbMiss   (evTlbMiss),
    .reason      (reason)
  );

  srs_control u_ctl (
    .clk         (clk),
    .rstN        (rstN),
    .evStart     (evStart),
    .evCommit    (evCommit),
    .evProtAccess(evProtAccess),
    .reason      (reason),
    .inRegion    (inRegion),
    .trackLine   (trackLine),
    .abortValid  (abortValid),
    .zfClear     (zfClear),
    .discardLines(discardLines),
    .commitDone  (commitDone),
    .flashClear  (flashClear),
    .strobe      (strobe)
  );

  srs_datapath #(.IP_W(IP_W), .LEN_W(LEN_W), .CODE_W(CODE_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .startIp  (startIp),
    .startLen (startLen),
    .startSp  (startSp),
    .reason   (reason),
    .restoreIp(restoreIp),
    .restoreSp(restoreSp),
    .abortCode(abortCode)
  );

  // R4: every abort cycle carries a nonzero reason
  p_code_on_abort_r4: assert property (@(posedge clk) disable iff (!rstN)
    abortValid |-> (abortCode != '0));

  // R4: outside the abort cycle the reason output is zero
  p_code_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
    !abortValid |-> (abortCode == '0));

  // R7: publishing and discarding never coincide
  p_commit_abort_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    !(flashClear && discardLines));

  // R9: a lone TLB miss keeps the region open
  p_tlb_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!ABORT_ON_TLB && inRegion && evTlbMiss && !evStart && !evCommit && !evAbort &&
     !evConflict && !evCapacity && !evInterrupt && !evException && !evSyscall &&
     !evDisallowed) |=> inRegion);
endmodule

// File: tb/spec_region_seq_tb.sv
module spec_region_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int IP_W = 64;
  localparam int LEN_W = 4;
  localparam int CODE_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evStart, evCommit, evAbort, evProtAccess, evConflict, evCapacity;
  logic evInterrupt, evException, evSyscall, evDisallowed, evTlbMiss;
  logic [IP_W-1:0] startIp, startSp;
  logic [LEN_W-1:0] startLen;
  logic inRegion, trackLine, abortValid, zfClear, discardLines, commitDone, flashClear;
  logic [IP_W-1:0] restoreIp, restoreSp;
  logic [CODE_W-1:0] abortCode;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spec_region_seq u_dut (
    .clk(clk), .rstN(rstN), .evStart(evStart), .evCommit(evCommit), .evAbort(evAbort),
    .evProtAccess(evProtAccess), .evConflict(evConflict), .evCapacity(evCapacity),
    .evInterrupt(evInterrupt), .evException(evException), .evSyscall(evSyscall),
    .evDisallowed(evDisallowed), .evTlbMiss(evTlbMiss), .startIp(startIp),
    .startLen(startLen), .startSp(startSp), .inRegion(inRegion), .trackLine(trackLine),
    .abortValid(abortValid), .restoreIp(restoreIp), .restoreSp(restoreSp),
    .abortCode(abortCode), .zfClear(zfClear), .discardLines(discardLines),
    .commitDone(commitDone), .flashClear(flashClear)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clearEv();
    evStart = 0; evCommit = 0; evAbort = 0; evProtAccess = 0; evConflict = 0;
    evCapacity = 0; evInterrupt = 0; evException = 0; evSyscall = 0;
    evDisallowed = 0; evTlbMiss = 0;
  endtask

  // advance past one rising edge; outputs are sampled 1 time unit later
  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic openRegion(input logic [63:0] ip, input logic [3:0] len, input logic [63:0] sp);
    startIp = ip; startLen = len; startSp = sp; evStart = 1;
    tick();
    clearEv();
    check("R2 inRegion after start", inRegion, 1);
  endtask

  task automatic expectAbort(input string req, input logic [7:0] code,
                             input logic [63:0] ip, input logic [63:0] sp);
    check({req, " abortValid"}, abortValid, 1);
    check({req, " abortCode"}, abortCode, code);
    check({req, " zfClear"}, zfClear, 1);
    check({req, " discardLines"}, discardLines, 1);
    check({req, " restoreIp"}, restoreIp, ip);
    check({req, " restoreSp"}, restoreSp, sp);
    check({req, " no flashClear"}, flashClear, 0);
    tick();
    check({req, " idle after abort"}, {abortValid, inRegion, abortCode}, 0);
  endtask

  task automatic testReset();
    check("R1 reset outputs",
          {inRegion, abortValid, zfClear, discardLines, commitDone, flashClear, trackLine}, 0);
    check("R1 reset abortCode", abortCode, 0);
  endtask

  task automatic testCommit();
    openRegion(64'h1000, 4'd3, 64'h8000);
    check("R2 restoreIp = ip+len", restoreIp, 64'h1003);
    check("R2 restoreSp", restoreSp, 64'h8000);
    evCommit = 1;
    tick(); clearEv();
    check("R6 commitDone", commitDone, 1);
    check("R6 flashClear", flashClear, 1);
    check("R6 no discard", discardLines, 0);
    check("R4 code zero on commit", abortCode, 0);
    tick();
    check("R6 idle after commit", {commitDone, flashClear, inRegion}, 0);
  endtask

  task automatic testSingle(input int which, input logic [7:0] code);
    openRegion(64'h2000 + 64'(which * 16), 4'd5, 64'h9000 - 64'(which));
    case (which)
      0: evAbort = 1;
      1: evConflict = 1;
      2: evCapacity = 1;
      3: evInterrupt = 1;
      4: evException = 1;
      5: evSyscall = 1;
      default: evDisallowed = 1;
    endcase
    tick(); clearEv();
    expectAbort("R3 R4 single cause", code, 64'h2005 + 64'(which * 16), 64'h9000 - 64'(which));
  endtask

  task automatic testPriority();
    openRegion(64'h3000, 4'd2, 64'h7000);
    evConflict = 1; evCapacity = 1; evSyscall = 1;
    tick(); clearEv();
    expectAbort("R5 contention beats capacity/syscall", 8'd2, 64'h3002, 64'h7000);
    openRegion(64'h3100, 4'd2, 64'h7100);
    evInterrupt = 1; evDisallowed = 1;
    tick(); clearEv();
    expectAbort("R5 interrupt beats disallowed", 8'd4, 64'h3102, 64'h7100);
    openRegion(64'h3200, 4'd1, 64'h7200);
    evAbort = 1; evConflict = 1; evCapacity = 1; evException = 1; evSyscall = 1;
    tick(); clearEv();
    expectAbort("R5 explicit beats all", 8'd1, 64'h3201, 64'h7200);
  endtask

  task automatic testCommitCollision();
    openRegion(64'h4000, 4'd4, 64'h6000);
    evCommit = 1; evCapacity = 1;
    tick(); clearEv();
    check("R7 no commitDone on collision", commitDone, 0);
    expectAbort("R7 abort wins over commit", 8'd3, 64'h4004, 64'h6000);
  endtask

  task automatic testNested();
    openRegion(64'h5000, 4'd6, 64'h5555);
    startIp = 64'hAAAA; startLen = 4'd1; startSp = 64'hBBBB; evStart = 1;
    tick(); clearEv();
    expectAbort("R8 nested start", 8'd5, 64'h5006, 64'h5555);
  endtask

  task automatic testTlb();
    openRegion(64'h6000, 4'd2, 64'h4000);
    evTlbMiss = 1;
    tick(); clearEv();
    check("R9 region open after TLB miss", inRegion, 1);
    check("R9 no abort after TLB miss", abortValid, 0);
    evCommit = 1;
    tick(); clearEv();
    check("R9 commit still possible", commitDone, 1);
    tick();
  endtask

  task automatic testIgnored();
    evCommit = 1; evAbort = 1; evInterrupt = 1; evConflict = 1;
    tick(); clearEv();
    check("R10 idle events ignored",
          {inRegion, abortValid, commitDone, flashClear, discardLines}, 0);
    openRegion(64'h7000, 4'd2, 64'h3000);
    evAbort = 1;
    tick(); clearEv();
    check("R10 abort cycle", abortValid, 1);
    startIp = 64'hCC00; startLen = 4'd1; startSp = 64'hDD00; evStart = 1; evAbort = 1;
    tick(); clearEv();
    check("R10 start in abort cycle ignored", {inRegion, abortValid}, 0);
    check("R10 checkpoint untouched", restoreIp, 64'h7002);
    openRegion(64'h7100, 4'd2, 64'h3100);
    evCommit = 1;
    tick(); clearEv();
    evStart = 1;
    tick(); clearEv();
    check("R10 start in commit cycle ignored", inRegion, 0);
  endtask

  task automatic testTrack();
    evProtAccess = 1;
    #1;
    check("R11 trackLine 0 when idle", trackLine, 0);
    clearEv();
    openRegion(64'h8000, 4'd2, 64'h2000);
    evProtAccess = 1;
    #1;
    check("R11 trackLine in region", trackLine, 1);
    tick(); clearEv();
    #1;
    check("R11 trackLine drops", trackLine, 0);
    check("R11 access keeps region", inRegion, 1);
    evAbort = 1;
    tick(); clearEv();
    tick();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    clearEv();
    startIp = '0; startLen = '0; startSp = '0;
    #(CLK_PERIOD * 3);
    testReset();
    @(negedge clk);
    rstN = 1'b1;
    tick();
    testReset();
    testCommit();
    for (int i = 0; i < 7; i++) begin
      testSingle(i, (i == 0) ? 8'd1 : (i == 1) ? 8'd2 : (i == 2) ? 8'd3 :
                    (i <= 4) ? 8'd4 : 8'd5);
    end
    testPriority();
    testCommitCollision();
    testNested();
    testTlb();
    testIgnored();
    testTrack();
    finishRun();
  end
endmodule